// File: doc/BRIEF.md
# Host-side Baseband Serial Data Port

This block sits on the host side of a spread-spectrum baseband processor and carries frame bytes across its serial data lines. On the transmit side a host offers bytes on a valid/ready interface. The block raises a transmit envelope toward the baseband and holds back all payload until the baseband reports that its preamble and header are out. It then shifts each byte onto a serial line, least significant bit first, timed by a bit clock that the baseband drives. The baseband samples that line on the falling clock edge. The envelope is dropped after the final bit of the byte marked as last.

On the receive side the baseband drives a bit clock, a data line and a data-ready envelope. While the envelope is high, the block samples the data on each rising clock edge and packs the bits into bytes, least significant bit first. Each complete byte is delivered with a one-cycle valid pulse. If the envelope ends partway through a byte, the block raises a one-cycle error pulse.

All baseband-side inputs are asynchronous to the host clock. They pass through synchronisers, and clock edges are detected in the host clock domain. For this reason the host clock must run several times faster than either serial clock.

Top module: `bb_serial_port`

## Requirements
- R1: After reset, tx_env_o, tx_ready_o, tx_sd_o, rx_valid_o and rx_err_o are all low.
- R2: When a byte is offered while the transmitter is idle, tx_env_o rises. tx_ready_o stays low until tx_bb_rdy_i has been seen high, so no byte is consumed before the baseband is ready.
- R3: Transmit bits go out least significant bit first, and a high line means a one. Each bit is driven after a falling edge of tx_bb_clk_i and held across exactly the next falling edge. tx_sd_o is low whenever tx_env_o is low.
- R4: The bytes of a frame follow one another with no gap. At each byte boundary the next waiting byte is consumed, and its bit 0 is the bit sampled at the next falling edge.
- R5: After the falling edge that samples the final bit of a byte marked by tx_last_i, tx_env_o falls and no further byte is consumed.
- R6: If no byte is waiting at a byte boundary, tx_env_o falls after the current byte, which ends the frame.
- R7: After tx_env_o falls, a new frame does not start until tx_bb_rdy_i has been seen low, even if a byte is waiting.
- R8: While rx_env_i is high, rx_sd_i is sampled on each rising edge of rx_bb_clk_i, least significant bit first. Every eighth bit produces rx_byte_o with a one-cycle rx_valid_o pulse.
- R9: Rising edges of rx_bb_clk_i while rx_env_i is low are ignored. They produce no valid or error pulse and do not shift the byte alignment of the next frame.
- R10: When rx_env_i falls with a partial byte collected, rx_err_o pulses for one cycle, no byte is emitted, and the next frame starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_byte_i | input | DATA_W | Byte offered for transmit |
| tx_last_i | input | 1 | Offered byte ends the frame |
| tx_valid_i | input | 1 | Offered byte valid |
| tx_ready_o | output | 1 | Offered byte consumed this cycle |
| tx_env_o | output | 1 | Transmit envelope to baseband |
| tx_bb_rdy_i | input | 1 | Baseband preamble/header done |
| tx_bb_clk_i | input | 1 | Baseband transmit bit clock |
| tx_sd_o | output | 1 | Serial transmit data |
| rx_bb_clk_i | input | 1 | Baseband receive bit clock |
| rx_sd_i | input | 1 | Serial receive data |
| rx_env_i | input | 1 | Receive data-ready envelope |
| rx_byte_o | output | DATA_W | Received byte |
| rx_valid_o | output | 1 | Received byte valid pulse |
| rx_err_o | output | 1 | Partial byte at envelope end |

## Verification
A wrong bit counter or shift register in the transmitter shows up at the next serial falling edge as a wrong bit, or as a frame whose bit count is not a multiple of the byte width. The bench compares every captured bit of every frame. A wrong transmit state appears within one serial bit time: the envelope is raised early or dropped late, or the ready signal fires before the baseband's ready input. On the receive side, a stale bit count first appears as shifted byte values in the frame after a partial byte or after clocks outside the envelope. A bad error flag appears at the envelope's falling edge.

// File: rtl/bbsp_pkg.sv
package bbsp_pkg;
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_WAIT  = 2'd1,
    TX_SHIFT = 2'd2,
    TX_END   = 2'd3
  } tx_state_e;
endpackage

// File: rtl/bbsp_sync.sv
module bbsp_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/bbsp_tx.sv
module bbsp_tx
  import bbsp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              last_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              bb_rdy_s_i,
  input  logic              bb_clk_s_i,
  output logic              env_o,
  output logic              sd_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] sreg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              last_q;
  logic              clk_prev_q;
  logic              clk_fall;
  logic              at_boundary;
  logic              take;

  assign clk_fall    = clk_prev_q & ~bb_clk_s_i;
  assign at_boundary = (state_q == TX_SHIFT) && clk_fall && (cnt_q == CNT_MAX);
  // a byte is taken only where the line needs its first bit
  assign ready_o = ((state_q == TX_WAIT) && bb_rdy_s_i) || (at_boundary && !last_q);
  assign take    = ready_o && valid_i;

  assign env_o = (state_q == TX_WAIT) || (state_q == TX_SHIFT);
  assign sd_o  = (state_q == TX_SHIFT) ? sreg_q[0] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= TX_IDLE;
      sreg_q     <= '0;
      cnt_q      <= '0;
      last_q     <= 1'b0;
      clk_prev_q <= 1'b0;
    end else begin
      clk_prev_q <= bb_clk_s_i;
      unique case (state_q)
        TX_IDLE: if (valid_i) state_q <= TX_WAIT;
        TX_WAIT: begin
          if (bb_rdy_s_i) begin
            if (take) begin
              sreg_q  <= byte_i;
              last_q  <= last_i;
              cnt_q   <= '0;
              state_q <= TX_SHIFT;
            end else begin
              state_q <= TX_END;
            end
          end
        end
        TX_SHIFT: begin
          if (clk_fall) begin
            if (cnt_q == CNT_MAX) begin
              if (take) begin
                sreg_q <= byte_i;
                last_q <= last_i;
                cnt_q  <= '0;
              end else begin
                state_q <= TX_END;
              end
            end else begin
              sreg_q <= sreg_q >> 1;
              cnt_q  <= cnt_q + 1'b1;
            end
          end
        end
        TX_END: if (!bb_rdy_s_i) state_q <= TX_IDLE;
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bbsp_rx.sv
module bbsp_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bb_clk_s_i,
  input  logic              sd_s_i,
  input  logic              env_s_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sreg_q;
  logic [DATA_W-1:0] next_sreg;
  logic [CNT_W-1:0]  cnt_q;
  logic              clk_prev_q;
  logic              env_prev_q;
  logic              clk_rise;
  logic              env_rise;
  logic              env_fall;

  assign clk_rise  = ~clk_prev_q & bb_clk_s_i;
  assign env_rise  = ~env_prev_q & env_s_i;
  assign env_fall  = env_prev_q & ~env_s_i;
  assign next_sreg = {sd_s_i, sreg_q[DATA_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q     <= '0;
      cnt_q      <= '0;
      byte_o     <= '0;
      valid_o    <= 1'b0;
      err_o      <= 1'b0;
      clk_prev_q <= 1'b0;
      env_prev_q <= 1'b0;
    end else begin
      clk_prev_q <= bb_clk_s_i;
      env_prev_q <= env_s_i;
      valid_o    <= 1'b0;
      err_o      <= 1'b0;
      if (env_fall) begin
        err_o <= (cnt_q != '0);
        cnt_q <= '0;
      end else if (env_rise) begin
        cnt_q <= '0;
        if (clk_rise) begin
          sreg_q <= next_sreg;
          cnt_q  <= CNT_W'(1);
        end
      end else if (env_s_i && clk_rise) begin
        sreg_q <= next_sreg;
        if (cnt_q == CNT_MAX) begin
          byte_o  <= next_sreg;
          valid_o <= 1'b1;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bb_serial_port.sv
module bb_serial_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_last_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              tx_env_o,
  input  logic              tx_bb_rdy_i,
  input  logic              tx_bb_clk_i,
  output logic              tx_sd_o,
  input  logic              rx_bb_clk_i,
  input  logic              rx_sd_i,
  input  logic              rx_env_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_err_o
);
  logic [1:0] tx_s;
  logic [2:0] rx_s;

  bbsp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_tx_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({tx_bb_rdy_i, tx_bb_clk_i}),
    .sync_o (tx_s)
  );

  bbsp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_rx_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({rx_env_i, rx_sd_i, rx_bb_clk_i}),
    .sync_o (rx_s)
  );

  bbsp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_i    (tx_byte_i),
    .last_i    (tx_last_i),
    .valid_i   (tx_valid_i),
    .ready_o   (tx_ready_o),
    .bb_rdy_s_i(tx_s[1]),
    .bb_clk_s_i(tx_s[0]),
    .env_o     (tx_env_o),
    .sd_o      (tx_sd_o)
  );

  bbsp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bb_clk_s_i(rx_s[0]),
    .sd_s_i    (rx_s[1]),
    .env_s_i   (rx_s[2]),
    .byte_o    (rx_byte_o),
    .valid_o   (rx_valid_o),
    .err_o     (rx_err_o)
  );
endmodule

// File: rtl/bbsp_chk.sv
module bbsp_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] tx_byte_i,
  input logic              tx_last_i,
  input logic              tx_valid_i,
  input logic              tx_ready_o,
  input logic              tx_env_o,
  input logic              tx_bb_rdy_i,
  input logic              tx_bb_clk_i,
  input logic              tx_sd_o,
  input logic              rx_bb_clk_i,
  input logic              rx_sd_i,
  input logic              rx_env_i,
  input logic [DATA_W-1:0] rx_byte_o,
  input logic              rx_valid_o,
  input logic              rx_err_o
);
  // R2
  ready_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> tx_env_o);

  // R2
  env_needs_offer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_env_o) |-> $past(tx_valid_i));

  // R3
  line_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_env_o |-> !tx_sd_o);

  // R7
  env_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_env_o) |=> !tx_env_o);

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R10
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_err_o |=> !rx_err_o);
endmodule

bind bb_serial_port bbsp_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bb_serial_port_tb_top.sv
module bb_serial_port_tb_top;
  localparam int DW = 8;
  localparam int NFR = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] tx_byte = '0;
  logic          tx_last = 1'b0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic          tx_env;
  logic          tx_bb_rdy = 1'b0;
  logic          tx_bb_clk = 1'b0;
  logic          tx_sd;
  logic          rx_bb_clk = 1'b0;
  logic          rx_sd = 1'b0;
  logic          rx_env = 1'b0;
  logic [DW-1:0] rx_byte;
  logic          rx_valid;
  logic          rx_err;

  int total = 0;
  int bad = 0;
  bit tx_done = 0;

  always #2.5 clk = ~clk;

  bb_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_byte_i(tx_byte), .tx_last_i(tx_last), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_env_o(tx_env), .tx_bb_rdy_i(tx_bb_rdy), .tx_bb_clk_i(tx_bb_clk), .tx_sd_o(tx_sd),
    .rx_bb_clk_i(rx_bb_clk), .rx_sd_i(rx_sd), .rx_env_i(rx_env),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .rx_err_o(rx_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int frame_len(input int f);
    return (f == NFR - 1) ? 2 : f + 1;
  endfunction

  function automatic logic [DW-1:0] tx_exp(input int f, input int k);
    if (f == 3) return k[0] ? 8'h00 : 8'hFF;
    return DW'((f * 53 + k * 29 + 7) & 255);
  endfunction

  function automatic logic [DW-1:0] rx_exp(input int g);
    return DW'((g * 71 + 19) & 255) ^ 8'h5A;
  endfunction

  // host byte source; last frame omits the last flag (underrun, R6)
  task automatic host_tx();
    for (int f = 0; f < NFR; f++) begin
      for (int k = 0; k < frame_len(f); k++) begin
        @(negedge clk);
        tx_byte  = tx_exp(f, k);
        tx_last  = (f != NFR - 1) && (k == frame_len(f) - 1);
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        if (f == NFR - 1 && k == frame_len(f) - 1) begin
          @(negedge clk);
          tx_valid = 1'b0;
        end
      end
    end
  endtask

  // baseband model: captures bits on its own falling edges
  task automatic bb_tx();
    bit bits[64];
    for (int f = 0; f < NFR; f++) begin
      int nb = 0;
      bit early = 0;
      bit rest_hi = 0;
      while (!tx_env) @(negedge clk);
      repeat (20) begin
        @(negedge clk);
        if (tx_ready) early = 1;
      end
      chk(!early, "R2 ready before baseband ready", early, 0);
      tx_bb_rdy = 1'b1;
      repeat (10) @(negedge clk);
      while (tx_env && nb < 64) begin
        tx_bb_clk = 1'b1;
        repeat (8) @(negedge clk);
        tx_bb_clk = 1'b0;
        bits[nb] = tx_sd;
        nb++;
        repeat (8) @(negedge clk);
      end
      chk(nb == 8 * frame_len(f), (f == NFR - 1) ? "R6 bit count" : "R5 bit count",
          nb, 8 * frame_len(f));
      for (int k = 0; k < frame_len(f); k++) begin
        logic [DW-1:0] got;
        for (int b = 0; b < 8; b++) got[b] = bits[k * 8 + b];
        chk(got == tx_exp(f, k), (k == 0) ? "R3 byte" : "R4 byte", got, tx_exp(f, k));
      end
      chk(!tx_sd, "R3 line low after frame", tx_sd, 0);
      repeat (40) begin
        @(negedge clk);
        if (tx_env) rest_hi = 1;
      end
      if (f < NFR - 1) chk(!rest_hi, "R7 restart while ready high", rest_hi, 0);
      tx_bb_rdy = 1'b0;
    end
  endtask

  int rx_got[64];
  int rx_n = 0;
  int err_n = 0;

  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_n < 64) begin
      rx_got[rx_n] = int'(rx_byte);
      rx_n++;
    end
    if (rst_n && rx_err) err_n++;
  end

  task automatic rx_bit(input bit b);
    rx_sd = b;
    repeat (4) @(negedge clk);
    rx_bb_clk = 1'b1;
    repeat (8) @(negedge clk);
    rx_bb_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // sends nbits of the stream starting at byte index g0
  task automatic rx_frame(input int g0, input int nbits);
    rx_env = 1'b1;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      logic [DW-1:0] v;
      v = rx_exp(g0 + i / 8);
      rx_bit(v[i % 8]);
    end
    repeat (6) @(negedge clk);
    rx_env = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic rx_expect(input int g0, input int n0, input int cnt, input string req);
    chk(rx_n == n0 + cnt, req, rx_n, n0 + cnt);
    for (int i = 0; i < cnt && n0 + i < rx_n; i++)
      chk(rx_got[n0 + i] == int'(rx_exp(g0 + i)), req, rx_got[n0 + i], int'(rx_exp(g0 + i)));
  endtask

  initial begin
    int n0, e0;
    repeat (3) @(negedge clk);
    // R1
    chk(!tx_env && !tx_ready && !tx_sd, "R1 tx idle", {tx_env, tx_ready, tx_sd}, 0);
    chk(!rx_valid && !rx_err, "R1 rx idle", {rx_valid, rx_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_env, "R1 env after reset", tx_env, 0);
    fork
      host_tx();
      bb_tx();
    join
    tx_done = 1;
    repeat (10) @(negedge clk);

    // R8: three bytes
    n0 = rx_n; e0 = err_n;
    rx_frame(0, 24);
    rx_expect(0, n0, 3, "R8 rx bytes");
    chk(err_n == e0, "R8 no error on whole frame", err_n - e0, 0);

    // R9: clocks outside envelope
    n0 = rx_n; e0 = err_n;
    for (int i = 0; i < 5; i++) rx_bit(1'b1);
    repeat (10) @(negedge clk);
    chk(rx_n == n0 && err_n == e0, "R9 ignored clocks", rx_n - n0 + err_n - e0, 0);
    rx_frame(3, 16);
    rx_expect(3, n0, 2, "R9 alignment");

    // R10: partial byte then fresh frame
    n0 = rx_n; e0 = err_n;
    rx_frame(5, 12);
    rx_expect(5, n0, 1, "R10 byte before partial");
    chk(err_n == e0 + 1, "R10 error pulse", err_n - e0, 1);
    n0 = rx_n; e0 = err_n;
    rx_frame(6, 8);
    rx_expect(6, n0, 1, "R10 fresh alignment");
    chk(err_n == e0, "R10 no error on next frame", err_n - e0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R1-chain actual=hung expected=done tx_done=%0d", tx_done);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule